// File: doc/BRIEF.md
# Inter-Processor Interrupt Send Router

The router takes 64-bit send commands issued by any core of a multi-core system and carries them to the per-core interrupt register units. A 2-bit command kind selects one of three operations. A vector send raises one pending interrupt bit in a target core. A mailbox send stores a 32-bit word in one of eight mailbox words of the target core. An offset send stores a 32-bit word at any 16-bit register offset of the target. Every command names its target core in the same field, and a command aimed at a core that does not exist is dropped with an error.

Mailbox and offset sends carry a 4-bit keep mask, one bit per byte lane. A set bit keeps the byte already stored at the target and discards the payload byte. When any keep bit is set, the router reads the target word on the target bus, merges it with the payload and writes the result back. When no keep bit is set, it writes the payload straight away with no read. Each command ends with a one-cycle completion pulse that carries an error flag. A read or write error on the target bus, or an invalid target, is returned through that flag. While a bus sequence is in flight, the router reports busy and ignores new commands.

Top module: `ipi_send_router`

## Requirements
- R1: The target core is `cmd_data[25:16]`. Kind 3 is reserved. A reserved kind, or a core number at or above `NUM_CORES`, produces `done_valid` with `done_err`=1 one cycle after acceptance, and no vector pulse and no bus request.
- R2: Kind 0 (vector send) to a valid core produces `vec_valid` for one cycle, one cycle after acceptance. It carries `vec_core` = core and `vec_bit` = `cmd_data[4:0]`, together with `done_valid` and `done_err`=0. It makes no bus request.
- R3: Kind 1 (mailbox send) addresses the target at `MBOX_BASE + 4*cmd_data[4:2]`, with `MBOX_BASE` defaulting to 0x20.
- R4: Kind 2 (offset send) addresses the target at `cmd_data[15:0]`.
- R5: The payload is `cmd_data[63:32]`. When the keep mask `cmd_data[30:27]` is zero, the only bus access is one write (`bus_we`=1) of the payload.
- R6: When the keep mask is non-zero, the router first reads (`bus_we`=0) the same core and address. It then writes a word whose byte lane i (bits 8i+7:8i) comes from the read data if mask bit `cmd_data[27+i]` is set, and from the payload otherwise.
- R7: `cmd_busy` is high from the cycle after a bus command is accepted until its completion. While busy, `cmd_valid` is ignored.
- R8: A read that completes with `bus_err`=1 ends the command with `done_err`=1 and issues no write.
- R9: The completion of a write reports `done_err` equal to `bus_err` at the write's acknowledge, one cycle after that acknowledge.
- R10: After reset, `cmd_busy`, `bus_req`, `vec_valid` and `done_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_kind | input | 2 | 0 vector, 1 mailbox, 2 offset, 3 reserved |
| cmd_data | input | 64 | Command word |
| cmd_busy | output | 1 | Bus sequence in flight, commands ignored |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion error flag |
| vec_valid | output | 1 | Vector pulse to the target core |
| vec_core | output | 10 | Core receiving the vector |
| vec_bit | output | 5 | Pending bit to set |
| bus_req | output | 1 | Target bus request, held until acknowledged |
| bus_we | output | 1 | 1 write, 0 read |
| bus_core | output | 10 | Target core on the bus |
| bus_addr | output | 16 | Target register offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Bus access complete |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_err | input | 1 | Bus access failed, valid with bus_ack |

## Verification
Vector sends, invalid targets and reserved kinds must complete exactly one cycle after the accepting edge. Each expected item for these commands carries that due cycle, and the monitor compares it against a free-running cycle count. A bus completion is due one cycle after the acknowledging edge, so the responder records the cycle in which it raises `bus_ack` and the monitor requires the completion one cycle later. Bus accesses are checked in issue order against the core, the address, the direction and the merged data. Any output pulse that arrives while nothing is expected, as a command offered during busy would cause, counts as a failure.

// File: rtl/ipi_router_pkg.sv
package ipi_router_pkg;
  localparam int CORE_W  = 10;
  localparam int ADDR_W  = 16;
  localparam int WORD_W  = 32;
  localparam int LANES   = WORD_W / 8;
  localparam int VBIT_W  = 5;

  typedef enum logic [1:0] {
    KIND_VECTOR = 2'd0,
    KIND_MAIL   = 2'd1,
    KIND_OFFSET = 2'd2,
    KIND_RSVD   = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [CORE_W-1:0] core;
    logic              ok;
    logic              is_vec;
    logic [VBIT_W-1:0] vbit;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  keep;
    logic [WORD_W-1:0] payload;
  } cmd_fields_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_router_pkg::*;
#(
  parameter int                NUM_CORES = 4,
  parameter logic [ADDR_W-1:0] MBOX_BASE = 16'h0020
) (
  input  logic [1:0]  kind,
  input  logic [63:0] data,
  output cmd_fields_t fields
);
  localparam int CORE_LSB = 16;
  localparam int KEEP_LSB = 27;

  logic [CORE_W-1:0] core;
  logic [ADDR_W-1:0] mail_addr;

  assign core      = data[CORE_LSB +: CORE_W];
  assign mail_addr = MBOX_BASE + {{(ADDR_W-5){1'b0}}, data[4:2], 2'b00};

  always_comb begin
    fields         = '0;
    fields.core    = core;
    fields.ok      = (cmd_kind_e'(kind) != KIND_RSVD) && (32'(core) < NUM_CORES);
    fields.is_vec  = (cmd_kind_e'(kind) == KIND_VECTOR);
    fields.vbit    = data[VBIT_W-1:0];
    fields.addr    = (cmd_kind_e'(kind) == KIND_MAIL) ? mail_addr : data[ADDR_W-1:0];
    fields.keep    = data[KEEP_LSB +: LANES];
    fields.payload = data[63:32];
  end
endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge
  import ipi_router_pkg::*;
(
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] new_word,
  input  logic [LANES-1:0]  keep,
  output logic [WORD_W-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*8 +: 8] = keep[g] ? old_word[g*8 +: 8] : new_word[g*8 +: 8];
  end
endmodule

// File: rtl/ipi_merge_seq.sv
module ipi_merge_seq
  import ipi_router_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  cmd_fields_t        fields,
  output logic               cmd_busy,
  output logic               done_valid,
  output logic               done_err,
  output logic               vec_valid,
  output logic [CORE_W-1:0]  vec_core,
  output logic [VBIT_W-1:0]  vec_bit,
  output logic               bus_req,
  output logic               bus_we,
  output logic [CORE_W-1:0]  bus_core,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [WORD_W-1:0]  bus_wdata,
  input  logic               bus_ack,
  input  logic [WORD_W-1:0]  bus_rdata,
  input  logic               bus_err
);
  seq_state_e        state;
  logic [LANES-1:0]  hold_keep;
  logic [WORD_W-1:0] hold_payload;
  logic [WORD_W-1:0] merged;

  ipi_byte_merge u_merge (
    .old_word (bus_rdata),
    .new_word (hold_payload),
    .keep     (hold_keep),
    .merged   (merged)
  );

  assign cmd_busy = (state != SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SEQ_IDLE;
      hold_keep    <= '0;
      hold_payload <= '0;
      done_valid   <= 1'b0;
      done_err     <= 1'b0;
      vec_valid    <= 1'b0;
      vec_core     <= '0;
      vec_bit      <= '0;
      bus_req      <= 1'b0;
      bus_we       <= 1'b0;
      bus_core     <= '0;
      bus_addr     <= '0;
      bus_wdata    <= '0;
    end else begin
      done_valid <= 1'b0;
      vec_valid  <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (cmd_valid) begin
            if (!fields.ok) begin
              done_valid <= 1'b1;
              done_err   <= 1'b1;
            end else if (fields.is_vec) begin
              vec_valid  <= 1'b1;
              vec_core   <= fields.core;
              vec_bit    <= fields.vbit;
              done_valid <= 1'b1;
              done_err   <= 1'b0;
            end else begin
              hold_keep    <= fields.keep;
              hold_payload <= fields.payload;
              bus_core     <= fields.core;
              bus_addr     <= fields.addr;
              bus_req      <= 1'b1;
              if (fields.keep != '0) begin
                bus_we <= 1'b0;
                state  <= SEQ_READ;
              end else begin
                bus_we    <= 1'b1;
                bus_wdata <= fields.payload;
                state     <= SEQ_WRITE;
              end
            end
          end
        end
        SEQ_READ: begin
          if (bus_ack) begin
            if (bus_err) begin
              bus_req    <= 1'b0;
              done_valid <= 1'b1;
              done_err   <= 1'b1;
              state      <= SEQ_IDLE;
            end else begin
              bus_we    <= 1'b1;
              bus_wdata <= merged;
              state     <= SEQ_WRITE;
            end
          end
        end
        SEQ_WRITE: begin
          if (bus_ack) begin
            bus_req    <= 1'b0;
            bus_we     <= 1'b0;
            done_valid <= 1'b1;
            done_err   <= bus_err;
            state      <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_core));

  // R6
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_we && bus_ack && !bus_err |=> bus_req && bus_we && !done_valid);

  // R8
  rd_err_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_we && bus_ack && bus_err |=> done_valid && done_err && !bus_req);

  // R9
  wr_done_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && bus_ack |=> done_valid && (done_err == $past(bus_err)) && !bus_req);

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_busy |=> !vec_valid);
endmodule

// File: rtl/ipi_send_router.sv
module ipi_send_router
  import ipi_router_pkg::*;
#(
  parameter int                NUM_CORES = 4,
  parameter logic [ADDR_W-1:0] MBOX_BASE = 16'h0020
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_kind,
  input  logic [63:0]        cmd_data,
  output logic               cmd_busy,
  output logic               done_valid,
  output logic               done_err,
  output logic               vec_valid,
  output logic [CORE_W-1:0]  vec_core,
  output logic [VBIT_W-1:0]  vec_bit,
  output logic               bus_req,
  output logic               bus_we,
  output logic [CORE_W-1:0]  bus_core,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [WORD_W-1:0]  bus_wdata,
  input  logic               bus_ack,
  input  logic [WORD_W-1:0]  bus_rdata,
  input  logic               bus_err
);
  cmd_fields_t fields;

  ipi_cmd_decode #(
    .NUM_CORES (NUM_CORES),
    .MBOX_BASE (MBOX_BASE)
  ) u_decode (
    .kind   (cmd_kind),
    .data   (cmd_data),
    .fields (fields)
  );

  ipi_merge_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .fields     (fields),
    .cmd_busy   (cmd_busy),
    .done_valid (done_valid),
    .done_err   (done_err),
    .vec_valid  (vec_valid),
    .vec_core   (vec_core),
    .vec_bit    (vec_bit),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_core   (bus_core),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err)
  );

  // R1
  bad_target_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_busy && (32'(cmd_data[25:16]) >= NUM_CORES)
      |=> done_valid && done_err && !vec_valid && !bus_req);

  // R2
  vec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> done_valid && !done_err && !bus_req);
endmodule

// File: tb/ipi_send_router_tb.sv
module ipi_send_router_tb;
  localparam int NUM_CORES = 4;

  typedef struct packed {
    logic [1:0]  typ;   // 0 vector, 1 read, 2 write, 3 done
    logic [9:0]  core;
    logic [15:0] addr;
    logic [31:0] wd;
    logic        err;
    logic [4:0]  vb;
    int          req;
    int          due;   // -1 none, -2 last ack + 1, else cycle
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic [63:0] cmd_data = '0;
  logic        cmd_busy, done_valid, done_err, vec_valid, bus_req, bus_we;
  logic [9:0]  vec_core, bus_core;
  logic [4:0]  vec_bit;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        bus_err = 1'b0;

  int   checks = 0, errors = 0, cyc = 0, last_ack = 0, wcnt = 0, lat = 0;
  logic [31:0] resp_rdata = 32'hAABBCCDD;
  bit   rd_err_next = 0, wr_err_next = 0;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ipi_send_router #(.NUM_CORES(NUM_CORES)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_data(cmd_data), .cmd_busy(cmd_busy), .done_valid(done_valid),
    .done_err(done_err), .vec_valid(vec_valid), .vec_core(vec_core),
    .vec_bit(vec_bit), .bus_req(bus_req), .bus_we(bus_we),
    .bus_core(bus_core), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [9:0] core, input logic [15:0] low,
                                     input logic [3:0] keep, input logic [31:0] pay);
    return {pay, 1'b0, keep, 1'b0, core, low};
  endfunction

  function automatic exp_t ev(input logic [1:0] typ, input int req, input int due);
    exp_t e = '0;
    e.typ = typ; e.req = req; e.due = due;
    return e;
  endfunction

  // Driver: computes expected items from the requirements and queues them.
  task automatic send(input logic [1:0] kind, input logic [63:0] d,
                      input int req, input bit wait_done);
    exp_t e;
    logic [9:0]  core = d[25:16];
    logic [3:0]  keep = d[30:27];
    logic [31:0] pay  = d[63:32];
    logic [15:0] addr;
    logic [31:0] m;
    @(negedge clk);
    while (cmd_busy) @(negedge clk);
    if (kind == 2'd3 || int'(core) >= NUM_CORES) begin           // R1
      e = ev(3, 1, cyc + 1); e.err = 1'b1; q.push_back(e);
    end else if (kind == 2'd0) begin                              // R2
      e = ev(0, 2, cyc + 1); e.core = core; e.vb = d[4:0]; q.push_back(e);
      e = ev(3, 2, cyc + 1); e.err = 1'b0; q.push_back(e);
    end else begin
      addr = (kind == 2'd1) ? 16'h0020 + {11'd0, d[4:2], 2'b00} : d[15:0]; // R3 R4
      if (keep != 4'd0) begin                                     // R6
        e = ev(1, 6, -1); e.core = core; e.addr = addr; q.push_back(e);
        if (rd_err_next) begin                                    // R8
          e = ev(3, 8, -2); e.err = 1'b1; q.push_back(e);
        end else begin
          for (int i = 0; i < 4; i++)
            m[i*8 +: 8] = keep[i] ? resp_rdata[i*8 +: 8] : pay[i*8 +: 8];
          e = ev(2, 6, -1); e.core = core; e.addr = addr; e.wd = m; q.push_back(e);
          e = ev(3, 9, -2); e.err = wr_err_next; q.push_back(e);
        end
      end else begin                                              // R5
        e = ev(2, 5, -1); e.core = core; e.addr = addr; e.wd = pay; q.push_back(e);
        e = ev(3, 9, -2); e.err = wr_err_next; q.push_back(e);
      end
    end
    cmd_kind = kind; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (wait_done) begin
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
    end
  endtask

  // Monitor and bus responder.
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      if (bus_ack) begin
        bus_ack = 1'b0; bus_err = 1'b0; wcnt = 0;
      end else if (bus_req) begin
        if (wcnt >= lat) begin
          if (q.size() == 0) chk(0, 7, "unexpected bus access", {63'd0, bus_we}, 64'd0);
          else begin
            e = q.pop_front();
            chk(e.typ == (bus_we ? 2'd2 : 2'd1), e.req, "bus direction", {62'd0, bus_we, 1'b0}, {62'd0, e.typ});
            chk(bus_core == e.core && bus_addr == e.addr, e.req, "bus core/addr",
                {38'd0, bus_core, bus_addr}, {38'd0, e.core, e.addr});
            if (bus_we) chk(bus_wdata == e.wd, e.req, "write data", {32'd0, bus_wdata}, {32'd0, e.wd});
          end
          bus_ack = 1'b1; bus_rdata = resp_rdata;
          if (bus_we) begin bus_err = wr_err_next; wr_err_next = 0; end
          else        begin bus_err = rd_err_next; rd_err_next = 0; end
          last_ack = cyc;
        end else wcnt++;
      end
      if (vec_valid) begin
        if (q.size() == 0 || q[0].typ != 2'd0) chk(0, 7, "unexpected vector", {54'd0, vec_core}, 64'd0);
        else begin
          e = q.pop_front();
          chk(vec_core == e.core && vec_bit == e.vb, e.req, "vector core/bit",
              {49'd0, vec_core, vec_bit}, {49'd0, e.core, e.vb});
          chk(cyc == e.due, e.req, "vector cycle", 64'(cyc), 64'(e.due));
        end
      end
      if (done_valid) begin
        if (q.size() == 0 || q[0].typ != 2'd3) chk(0, 7, "unexpected completion", {63'd0, done_err}, 64'd0);
        else begin
          e = q.pop_front();
          chk(done_err == e.err, e.req, "completion error", {63'd0, done_err}, {63'd0, e.err});
          if (e.due == -2) chk(cyc == last_ack + 1, e.req, "completion cycle", 64'(cyc), 64'(last_ack + 1));
          else chk(cyc == e.due, e.req, "completion cycle", 64'(cyc), 64'(e.due));
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!cmd_busy && !bus_req && !vec_valid && !done_valid, 10, "reset outputs",
        {60'd0, cmd_busy, bus_req, vec_valid, done_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R2: vector sends
    send(2'd0, mk(10'd2, 16'h0011, 4'h0, 32'h0), 2, 1);
    send(2'd0, mk(10'd3, 16'h001F, 4'hF, 32'hFFFF_FFFF), 2, 1);
    // R1: invalid core numbers and reserved kind
    send(2'd0, mk(10'd4, 16'h0001, 4'h0, 32'h0), 1, 1);
    send(2'd1, mk(10'd1023, 16'h0000, 4'h0, 32'h1234), 1, 1);
    send(2'd3, mk(10'd0, 16'h0000, 4'h0, 32'h0), 1, 1);
    // R3 R5: mailbox index 5, direct write
    send(2'd1, mk(10'd1, 16'h0014, 4'h0, 32'h1122_3344), 3, 1);
    // R4 R5: offset send, direct write, slow bus
    lat = 2;
    send(2'd2, mk(10'd0, 16'h1234, 4'h0, 32'hDEAD_BEEF), 4, 1);
    // R6: keep lanes 0 and 2 on a mailbox
    lat = 0; resp_rdata = 32'hAABB_CCDD;
    send(2'd1, mk(10'd3, 16'h001C, 4'h5, 32'h1122_3344), 6, 1);
    // R6: keep every lane on an offset send
    resp_rdata = 32'h0F1E_2D3C;
    send(2'd2, mk(10'd2, 16'hFFFC, 4'hF, 32'h5566_7788), 6, 1);
    // R6: keep lane 3 only
    lat = 1; resp_rdata = 32'h9900_0000;
    send(2'd2, mk(10'd1, 16'h0040, 4'h8, 32'h0102_0304), 6, 1);
    // R8: read error ends without a write
    rd_err_next = 1;
    send(2'd1, mk(10'd0, 16'h0000, 4'h2, 32'hCAFE_F00D), 8, 1);
    // R9: write error after a merge
    wr_err_next = 1; resp_rdata = 32'h1357_9BDF;
    send(2'd2, mk(10'd2, 16'h0100, 4'h1, 32'h2468_ACE0), 9, 1);
    // R9: write error on a direct write
    wr_err_next = 1;
    send(2'd1, mk(10'd3, 16'h0000, 4'h0, 32'h7777_7777), 9, 1);
    // R7: a command offered while busy is ignored
    lat = 4; resp_rdata = 32'h4444_4444;
    send(2'd1, mk(10'd1, 16'h0008, 4'h3, 32'h8888_8888), 7, 0);
    @(negedge clk);
    chk(cmd_busy == 1'b1, 7, "busy during sequence", {63'd0, cmd_busy}, 64'd1);
    cmd_kind = 2'd0; cmd_data = mk(10'd2, 16'h0007, 4'h0, 32'h0); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!cmd_busy, 7, "idle after sequence", {63'd0, cmd_busy}, 64'd0);
    // R2: vector accepted right after the busy period
    lat = 0;
    send(2'd0, mk(10'd0, 16'h0000, 4'h0, 32'h0), 2, 1);

    chk(q.size() == 0, 7, "leftover expectations", 64'(q.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule